// File: doc/BRIEF.md
# Serial Panel Register Access Controller

This block gives a parallel request port access to the 8-bit configuration registers of an LCD driver over a three-wire serial link: an active-low chip enable, a serial clock and one data line that turns around for reads. The requester supplies a 6-bit register address, a read/write flag, write data and a one-cycle start strobe. The block returns a one-cycle done pulse, with the register contents on `rdata` after a read.

The chip enable and serial clock wires are shared with a touch-screen converter. The block therefore asks an external arbiter for the wires, waits for the grant, and signals on `bus_drv` the cycles in which its pad drivers may own them. It drives chip enable high again before it gives the wires back. The serial data line is split at the pad into an output value, an output enable and an input value. The serial clock runs at the system clock divided by `2*HALF_DIV`.

Top module: `panel_sreg_ctrl`

## Requirements
- R1: Each transfer holds `cs_n` low for exactly 16 rising `sclk` edges. Sampled on those edges, the bits are: address bit 5 down to bit 0, then the direction bit (1 = read, 0 = write), then one turnaround bit, then data bit 7 down to bit 0. Every field is sent most significant bit first.
- R2: While `cs_n` stays low and `sclk` stays high, `sda_out` does not change. New bits appear only at falling `sclk` edges or together with the falling edge of `cs_n`.
- R3: In a read, `sda_oe` is high for the six address bits and the direction bit, and low from the turnaround bit to the end of the frame. The value of `sda_in` at each of the last eight rising edges is collected MSB first and appears on `rdata` with the done pulse.
- R4: In a write, `sda_oe` is high for all 16 bits, the turnaround bit is driven as 0, and the data bits carry `wdata`.
- R5: `sclk` is high whenever `cs_n` is high. The first falling `sclk` edge comes `HALF_DIV` clocks after `cs_n` falls, and each half period lasts `HALF_DIV` clocks.
- R6: `cs_n` rises exactly `2*HALF_DIV` clocks after the 16th rising `sclk` edge.
- R7: A start accepted while idle raises `bus_req`. Until `bus_gnt` is seen, `cs_n` stays high and `bus_drv` stays low. `cs_n` is low only while both `bus_drv` and `bus_gnt` are high, and `bus_drv` is high only while `bus_req` is high.
- R8: `done` is a single-cycle pulse that comes one clock after `cs_n` rises. In that same cycle `bus_req` and `bus_drv` are already low.
- R9: A start strobe that arrives while `busy` is high is ignored: it produces no extra frame, no extra done pulse and no change to the frame in progress.
- R10: After reset: `cs_n`=1, `sclk`=1, `sda_oe`=0, `bus_req`=0, `bus_drv`=0, `done`=0, `busy`=0, `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, taken only when idle |
| addr | input | 6 | Register address |
| rd | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Data for a write |
| busy | output | 1 | High from acceptance until the done pulse |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 8 | Data from the last read |
| bus_req | output | 1 | Request for the shared wires |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_drv | output | 1 | Enable for the shared `cs_n`/`sclk` pad drivers |
| cs_n | output | 1 | Active-low chip enable |
| sclk | output | 1 | Serial clock, idles high |
| sda_out | output | 1 | Serial data output value |
| sda_oe | output | 1 | Serial data output enable |
| sda_in | input | 1 | Serial data input value |

## Verification
The assertions assume that the arbiter keeps `bus_gnt` high from the grant until `bus_req` falls. They also assume that the slave changes `sda_in` only at falling `sclk` edges, so the value is settled by the next rising edge. The bench arbiter raises the grant after a chosen delay and holds it until the request drops. The slave model updates `sda_in` only in the system cycle that follows a falling `sclk` edge, which is `HALF_DIV` clocks before the block samples it. Start strobes arrive both in idle and in the middle of frames, and the latter must leave no trace on the wire.

// File: rtl/panel_sreg_pkg.sv
package panel_sreg_pkg;

    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    // address, direction bit, turnaround bit, data
    localparam int FRAME_W    = ADDR_W + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_W);
    // frame index of the first data bit
    localparam int FIRST_DATA = ADDR_W + 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_REL
    } xfer_state_e;

    typedef struct packed {
        xfer_state_e         st;
        logic [IDX_W-1:0]    idx;
        logic                hi;
        logic [ADDR_W-1:0]   addr;
        logic                rd;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rx;
        logic [DATA_W-1:0]   rdata;
        logic                cs_n;
        logic                sclk;
        logic                sdo;
        logic                oe;
        logic                req;
        logic                drv;
        logic                done;
    } ctrl_s;

    localparam ctrl_s CTRL_RESET = '{
        st:    ST_IDLE,
        idx:   '0,
        hi:    1'b0,
        addr:  '0,
        rd:    1'b0,
        wdata: '0,
        rx:    '0,
        rdata: '0,
        cs_n:  1'b1,
        sclk:  1'b1,
        sdo:   1'b0,
        oe:    1'b0,
        req:   1'b0,
        drv:   1'b0,
        done:  1'b0
    };

endpackage

// File: rtl/panel_sreg_tick.sv
module panel_sreg_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = en && (cnt_q == LAST);

endmodule

// File: rtl/panel_sreg_frame.sv
module panel_sreg_frame
    import panel_sreg_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd,
    input  logic [DATA_W-1:0]  wdata,
    output logic [FRAME_W-1:0] frame,
    output logic [FRAME_W-1:0] drive
);
    // The turnaround bit is sent as zero, and so is the data field of a read.
    assign frame = {addr, rd, 1'b0, (rd ? {DATA_W{1'b0}} : wdata)};

    // Bit position DATA_W is the turnaround bit. In a read the line is
    // released from that bit on.
    for (genvar p = 0; p < FRAME_W; p++) begin : g_drive
        if (p > DATA_W) begin : g_cmd
            assign drive[p] = 1'b1;
        end else begin : g_tail
            assign drive[p] = !rd;
        end
    end

endmodule

// File: rtl/panel_sreg_ctrl.sv
module panel_sreg_ctrl
    import panel_sreg_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_drv,
    output logic              cs_n,
    output logic              sclk,
    output logic              sda_out,
    output logic              sda_oe,
    input  logic              sda_in
);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_W - 1);
    localparam logic [IDX_W-1:0] DATA_IDX0 = IDX_W'(FIRST_DATA);

    ctrl_s r_d, r_q;

    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] drive;
    logic               tick;
    logic               tick_en;
    logic [IDX_W-1:0]   idx_next;
    logic [IDX_W-1:0]   pos_next;

    panel_sreg_frame i_frame (
        .addr  (r_q.addr),
        .rd    (r_q.rd),
        .wdata (r_q.wdata),
        .frame (frame),
        .drive (drive)
    );

    assign tick_en = (r_q.st == ST_LEAD) || (r_q.st == ST_SHIFT) || (r_q.st == ST_TAIL);

    panel_sreg_tick #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .tick  (tick)
    );

    assign idx_next = r_q.idx + 1'b1;
    assign pos_next = LAST_IDX - idx_next;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.addr  = addr;
                    r_d.rd    = rd;
                    r_d.wdata = wdata;
                    r_d.req   = 1'b1;
                    r_d.st    = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    r_d.st   = ST_LEAD;
                    r_d.drv  = 1'b1;
                    r_d.cs_n = 1'b0;
                    r_d.sclk = 1'b1;
                    r_d.idx  = '0;
                    r_d.hi   = 1'b0;
                    r_d.rx   = '0;
                    r_d.sdo  = frame[FRAME_W-1];
                    r_d.oe   = drive[FRAME_W-1];
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    r_d.st   = ST_SHIFT;
                    r_d.sclk = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!r_q.hi) begin
                        // rising edge: the slave samples, and so does the block in the data field of a read
                        r_d.hi   = 1'b1;
                        r_d.sclk = 1'b1;
                        if (r_q.rd && (r_q.idx >= DATA_IDX0)) begin
                            r_d.rx = {r_q.rx[DATA_W-2:0], sda_in};
                        end
                    end else if (r_q.idx == LAST_IDX) begin
                        r_d.st = ST_TAIL;
                    end else begin
                        // falling edge: present the next bit
                        r_d.hi   = 1'b0;
                        r_d.sclk = 1'b0;
                        r_d.idx  = idx_next;
                        r_d.sdo  = frame[pos_next];
                        r_d.oe   = drive[pos_next];
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    r_d.st   = ST_REL;
                    r_d.cs_n = 1'b1;
                    r_d.oe   = 1'b0;
                end
            end
            ST_REL: begin
                r_d.st   = ST_IDLE;
                r_d.drv  = 1'b0;
                r_d.req  = 1'b0;
                r_d.done = 1'b1;
                if (r_q.rd) begin
                    r_d.rdata = r_q.rx;
                end
            end
            default: r_d = CTRL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CTRL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign rdata   = r_q.rdata;
    assign bus_req = r_q.req;
    assign bus_drv = r_q.drv;
    assign cs_n    = r_q.cs_n;
    assign sclk    = r_q.sclk;
    assign sda_out = r_q.sdo;
    assign sda_oe  = r_q.oe;

endmodule

// File: rtl/panel_sreg_chk.sv
module panel_sreg_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic bus_req,
    input logic bus_gnt,
    input logic bus_drv,
    input logic cs_n,
    input logic sclk,
    input logic sda_out,
    input logic sda_oe
);
    // R2
    hold_data_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && sclk && $past(sclk)) |-> $stable(sda_out));

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R7
    cs_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (bus_drv && bus_gnt));

    // R7
    drv_under_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drv |-> bus_req);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_req && !bus_drv && cs_n));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && sclk && !bus_drv && !sda_oe && !bus_req));

    // R1
    frame_start_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> sda_oe);

endmodule

bind panel_sreg_ctrl panel_sreg_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .bus_req (bus_req),
    .bus_gnt (bus_gnt),
    .bus_drv (bus_drv),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .sda_out (sda_out),
    .sda_oe  (sda_oe)
);

// File: tb/test_panel_sreg_ctrl.sv
module test_panel_sreg_ctrl;
    localparam int H = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [5:0] addr = '0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic       busy, done, bus_req, bus_drv, cs_n, sclk, sda_out, sda_oe;
    logic [7:0] rdata;
    logic       bus_gnt = 1'b0;
    logic       sda_in = 1'b0;

    always #2 clk = ~clk;

    panel_sreg_ctrl #(.HALF_DIV(H)) i_panel_sreg_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .rd(rd),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_drv(bus_drv),
        .cs_n(cs_n), .sclk(sclk), .sda_out(sda_out), .sda_oe(sda_oe),
        .sda_in(sda_in)
    );

    typedef struct {
        logic [5:0] a;
        logic       r;
        logic [7:0] wd;
        logic [7:0] rb;
    } item_t;

    item_t q[$];
    item_t last_it;
    int    n_chk = 0;
    int    n_bad = 0;
    int    gnt_delay = 0;
    int    gcnt = 0;
    int    n_done = 0;
    int    n_items = 0;
    int    v_r2 = 0, v_r5 = 0, v_r7 = 0;
    bit    finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // arbiter: grant after gnt_delay cycles, hold until the request drops
    always @(posedge clk) begin
        if (!rst_n || !bus_req) begin
            bus_gnt <= 1'b0;
            gcnt    <= 0;
        end else if (gcnt >= gnt_delay) begin
            bus_gnt <= 1'b1;
        end else begin
            gcnt <= gcnt + 1;
        end
    end

    // monitor and slave, sampled on the falling system clock
    logic        p_cs = 1'b1, p_sclk = 1'b1, p_sdo = 1'b0;
    int          cyc = 0, t_fall = 0, t_rise = 0, rcnt = 0, fcnt = 0;
    logic [15:0] got_bits, got_oe;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cs_n && !sclk) v_r5++;
            if (!cs_n && !(bus_gnt && bus_drv)) v_r7++;
            if (!cs_n && !p_cs && sclk && p_sclk && (sda_out != p_sdo)) v_r2++;

            if (p_cs && !cs_n) begin
                rcnt = 0; fcnt = 0; t_fall = cyc;
                got_bits = '0; got_oe = '0;
            end
            if (!cs_n && p_sclk && !sclk) begin
                if (fcnt == 0)
                    check(cyc - t_fall == H, "R5", "cs fall to first sclk fall", cyc - t_fall, H);
                if (fcnt >= 8 && q.size() > 0) sda_in = q[0].rb[15 - fcnt];
                fcnt++;
            end
            if (!cs_n && !p_sclk && sclk) begin
                if (rcnt < 16) begin
                    got_bits[15 - rcnt] = sda_out;
                    got_oe[15 - rcnt]   = sda_oe;
                end
                rcnt++;
                t_rise = cyc;
            end
            if (!p_cs && cs_n) begin
                if (q.size() == 0) begin
                    check(0, "R9", "frame with no request", 1, 0);
                end else begin
                    logic [15:0] ef, em;
                    last_it = q.pop_front();
                    ef = {last_it.a, last_it.r, 1'b0, (last_it.r ? 8'h00 : last_it.wd)};
                    em = last_it.r ? 16'hFE00 : 16'hFFFF;
                    check(rcnt == 16, "R1", "rising edges per frame", rcnt, 16);
                    check((got_bits & em) == (ef & em), "R1", "frame bits", got_bits, ef);
                    if (last_it.r)
                        check(got_oe == em, "R3", "read drive mask", got_oe, em);
                    else
                        check(got_oe == em && got_bits[7:0] == last_it.wd && !got_bits[8],
                              "R4", "write drive/data", {got_oe, got_bits}, {em, ef});
                    check(cyc - t_rise == 2 * H, "R6", "last rise to cs rise", cyc - t_rise, 2 * H);
                end
                sda_in = 1'b0;
            end
            if (done) begin
                n_done++;
                check(!bus_req && !bus_drv && cs_n, "R8", "wires released at done",
                      {bus_req, bus_drv, cs_n}, 3'b001);
                check(!p_cs == 1'b0 && cs_n, "R8", "cs high before done", cs_n, 1);
                if (last_it.r)
                    check(rdata == last_it.rb, "R3", "read data", rdata, last_it.rb);
            end
        end
        p_cs = cs_n; p_sclk = sclk; p_sdo = sda_out;
    end

    task automatic xfer(input logic [5:0] a, input logic r, input logic [7:0] wd,
                        input logic [7:0] rb, input int gd, input bit extra);
        item_t it;
        int    d0;
        while (busy) @(negedge clk);
        gnt_delay = gd;
        it.a = a; it.r = r; it.wd = wd; it.rb = rb;
        q.push_back(it);
        n_items++;
        d0 = n_done;
        start = 1'b1; addr = a; rd = r; wdata = wd;
        @(negedge clk);
        start = 1'b0; addr = ~a; rd = ~r; wdata = ~wd;
        if (gd >= 6) begin
            repeat (4) @(negedge clk);
            check(bus_req && cs_n && !bus_drv && busy, "R7", "waiting for grant",
                  {bus_req, cs_n, bus_drv, busy}, 4'b1101);
        end
        if (extra) begin
            repeat (gd + 5 * H) @(negedge clk);
            // R9: strobe in the middle of the frame
            start = 1'b1; addr = 6'h3F; rd = 1'b0; wdata = 8'hA5;
            @(negedge clk);
            start = 1'b0;
        end
        while (n_done == d0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n && sclk && !sda_oe && !bus_req && !bus_drv && !done && !busy && rdata == 0,
              "R10", "reset state",
              {cs_n, sclk, sda_oe, bus_req, bus_drv, done, busy, rdata}, {7'b1100000, 8'h00});
        rst_n = 1'b1;
        @(negedge clk);
        xfer(6'h2A, 1'b0, 8'h5C, 8'h00, 0, 0);
        xfer(6'h15, 1'b1, 8'h00, 8'hB3, 2, 0);
        xfer(6'h3F, 1'b0, 8'hFF, 8'h00, 8, 0);
        xfer(6'h00, 1'b1, 8'h00, 8'h81, 1, 1);
        xfer(6'h01, 1'b0, 8'h00, 8'h00, 0, 1);
        xfer(6'h3F, 1'b1, 8'h00, 8'hFF, 7, 0);
        xfer(6'h20, 1'b1, 8'h00, 8'h00, 0, 0);
        xfer(6'h11, 1'b0, 8'h96, 8'h00, 3, 0);
        repeat (40) @(negedge clk);
        check(n_done == n_items && q.size() == 0, "R9", "done count equals requests", n_done, n_items);
        check(!busy && !bus_req && cs_n, "R9", "idle after ignored strobes", {busy, bus_req, cs_n}, 3'b001);
        check(v_r2 == 0, "R2", "data changed while sclk high", v_r2, 0);
        check(v_r5 == 0, "R5", "sclk low while cs high", v_r5, 0);
        check(v_r7 == 0, "R7", "cs low without grant", v_r7, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d done pulses", n_done, n_items);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule